// File: doc/BRIEF.md
# Tile Elementwise Floored Remainder Engine

This engine computes, element by element, the remainder of a dividend tile by a divisor tile. Both tiles and the destination tile live in row-major local buffers of a fixed capacity. The sign of every result follows the divisor (floored modulo), not the dividend. A caller pulses `start` together with a runtime valid row count, a valid column count and an element type. The engine then walks the valid sub-region in row-major order. For each element it reads both operands through one shared read address, works out the truncated remainder with an iterative restoring divider, applies the sign correction and writes the result to the destination buffer.

Cells of the destination outside the valid sub-region are never written. A zero divisor does not stop the walk: that element is written as zero and a sticky error flag is raised. A one-cycle `done` pulse follows the last write.

Top module: `tile_floor_rem`

## Requirements
- R1: Each written result equals a - b*floor(a/b). A nonzero result has the sign of the divisor b, and its magnitude is below |b|.
- R2: When the truncated remainder is nonzero and its sign differs from the divisor's, the result is the truncated remainder plus the divisor. Example: -7 by 3 gives 2, and 7 by -3 gives -2 (0xFFFFFFFE).
- R3: Elements are visited and written row by row, columns ascending. The write address of row r, column c is r*COLS + c.
- R4: Only cells with row < valid rows and column < valid columns are written. All other destination cells keep their contents.
- R5: `mode` selects the element type. 0 is signed 32-bit, 1 is unsigned 32-bit, 2 is signed 16-bit and 3 is unsigned 16-bit. In the 16-bit modes only the low 16 bits of each operand are used, the result is in the low 16 bits, and the upper 16 bits of `wr_data` are zero.
- R6: A valid row count above ROWS is treated as ROWS, and a valid column count above COLS is treated as COLS. A count of zero in either one gives a run with no writes.
- R7: A divisor of zero writes 0 to that element and sets `err_div0`. The walk then continues with the remaining elements. `err_div0` holds until the next accepted start clears it.
- R8: `done` is a single-cycle pulse, one cycle after the last write (or one cycle after start for an empty region). `busy` is high from the accepted start through the `done` cycle.
- R9: A `start` seen while `busy` is high is ignored. The run in progress keeps its own dimensions and mode.
- R10: After reset `busy`, `done`, `err_div0` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; sampled only when idle |
| valid_rows | input | DIMW | Runtime valid row count |
| valid_cols | input | DIMW | Runtime valid column count |
| mode | input | 2 | Element type select |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| err_div0 | output | 1 | Sticky zero-divisor flag |
| rd_addr | output | AW | Shared read address for both source buffers |
| src0_data | input | DW | Dividend element at `rd_addr` (combinational read) |
| src1_data | input | DW | Divisor element at `rd_addr` (combinational read) |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | AW | Destination write address |
| wr_data | output | DW | Destination write data |

## Verification
The hardest situation to reach is a sign-correcting remainder at the extremes of each element type. Examples are the most negative dividend against -1 or against the largest positive divisor, mixed with zero divisors in the middle of a region and with clamped, non-square sub-regions. The bench sweeps every element mode against every combination of row and column counts on a 3x4 tile, including zero and over-capacity counts. It fills the operand buffers with rotating picks from lists of edge values, with garbage in the upper halves for the 16-bit modes. It also fires a stray start in the middle of runs, so the rejection of a busy start is covered together with the arithmetic.

// File: rtl/tile_rem_pkg.sv
package tile_rem_pkg;

  typedef enum logic [1:0] {
    MODE_S32 = 2'd0,
    MODE_U32 = 2'd1,
    MODE_S16 = 2'd2,
    MODE_U16 = 2'd3
  } elem_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DIVIDE,
    ST_STORE,
    ST_FINISH
  } eng_state_e;

endpackage

// File: rtl/trem_walker.sv
module trem_walker #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DIMW = 8,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [DIMW-1:0] rows_in,
  input  logic [DIMW-1:0] cols_in,
  input  logic            step,
  output logic [AW-1:0]   addr,
  output logic            last
);

  logic [DIMW-1:0] row_lim, col_lim, row, col;
  logic [DIMW-1:0] rows_cl, cols_cl;

  assign rows_cl = (int'(rows_in) > ROWS) ? DIMW'(ROWS) : rows_in;
  assign cols_cl = (int'(cols_in) > COLS) ? DIMW'(COLS) : cols_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_lim <= '0;
      col_lim <= '0;
      row     <= '0;
      col     <= '0;
    end else if (load) begin
      row_lim <= rows_cl;
      col_lim <= cols_cl;
      row     <= '0;
      col     <= '0;
    end else if (step) begin
      if (col == col_lim - 1'b1) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign addr = AW'(int'(row) * COLS + int'(col));
  assign last = (row == row_lim - 1'b1) && (col == col_lim - 1'b1);

endmodule

// File: rtl/trem_divider.sv
module trem_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [DW-1:0] rem
);

  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] quo, rem_r;
  logic [DW:0]   shifted, trial;
  logic [CW-1:0] cnt;
  logic          active, ge;

  assign shifted = {rem_r, quo[DW-1]};
  assign trial   = shifted - {1'b0, den};
  assign ge      = !trial[DW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo    <= '0;
      rem_r  <= '0;
      cnt    <= '0;
      active <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quo    <= num;
        rem_r  <= '0;
        cnt    <= CW'(DW);
        active <= 1'b1;
      end else if (active) begin
        quo   <= {quo[DW-2:0], ge};
        rem_r <= ge ? trial[DW-1:0] : shifted[DW-1:0];
        cnt   <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          active <= 1'b0;
          fin    <= 1'b1;
        end
      end
    end
  end

  assign rem = rem_r;

endmodule

// File: rtl/tile_floor_rem.sv
module tile_floor_rem
  import tile_rem_pkg::*;
#(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 32,
  parameter int DIMW = 8,
  localparam int AW  = (ROWS * COLS > 1) ? $clog2(ROWS * COLS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DIMW-1:0] valid_rows,
  input  logic [DIMW-1:0] valid_cols,
  input  logic [1:0]      mode,
  output logic            busy,
  output logic            done,
  output logic            err_div0,
  output logic [AW-1:0]   rd_addr,
  input  logic [DW-1:0]   src0_data,
  input  logic [DW-1:0]   src1_data,
  output logic            wr_en,
  output logic [AW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data
);

  localparam int HW = DW / 2;

  function automatic logic signed [DW:0] widen(logic [DW-1:0] v, elem_mode_e m);
    case (m)
      MODE_S32: return {v[DW-1], v};
      MODE_U32: return {1'b0, v};
      MODE_S16: return {{(DW-HW+1){v[HW-1]}}, v[HW-1:0]};
      default:  return {{(DW-HW+1){1'b0}}, v[HW-1:0]};
    endcase
  endfunction

  function automatic logic [DW-1:0] magnitude(logic signed [DW:0] x);
    logic signed [DW:0] t;
    t = x[DW] ? -x : x;
    return t[DW-1:0];
  endfunction

  function automatic logic signed [DW:0] floor_fix(logic [DW-1:0] rmag, logic neg_num,
                                                   logic signed [DW:0] den);
    logic signed [DW:0] t;
    t = signed'({1'b0, rmag});
    if (neg_num) t = -t;
    if (t != '0 && (t[DW] != den[DW])) t = t + den;
    return t;
  endfunction

  function automatic logic [DW-1:0] narrow(logic signed [DW:0] r, elem_mode_e m);
    if (m == MODE_S16 || m == MODE_U16) return {{(DW-HW){1'b0}}, r[HW-1:0]};
    return r[DW-1:0];
  endfunction

  eng_state_e         state;
  elem_mode_e         mode_q;
  logic               num_neg_q, den_zero_q, err_q;
  logic signed [DW:0] den_ext;
  logic [DW-1:0]      den_mag_q, res_q, div_rem;
  logic signed [DW:0] a_w, b_w;
  logic               start_acc, zero_area, walk_last, div_go, div_fin;
  logic [AW-1:0]      walk_addr;

  // named events for the checker
  logic               ev_zero_div, ev_last_store;
  logic [1:0]         mode_bits;
  logic               den_neg;

  assign start_acc = start && (state == ST_IDLE);
  assign zero_area = (valid_rows == '0) || (valid_cols == '0);
  assign a_w       = widen(src0_data, mode_q);
  assign b_w       = widen(src1_data, mode_q);
  assign div_go    = (state == ST_FETCH) && (b_w != '0);

  trem_walker #(.ROWS(ROWS), .COLS(COLS), .DIMW(DIMW), .AW(AW)) walker_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_acc),
    .rows_in (valid_rows),
    .cols_in (valid_cols),
    .step    ((state == ST_STORE) && !walk_last),
    .addr    (walk_addr),
    .last    (walk_last)
  );

  trem_divider #(.DW(DW)) divider_i (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (magnitude(a_w)),
    .den   (den_mag_q),
    .fin   (div_fin),
    .rem   (div_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= MODE_S32;
      num_neg_q  <= 1'b0;
      den_zero_q <= 1'b0;
      den_ext    <= '0;
      den_mag_q  <= '0;
      res_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_acc) begin
          mode_q <= elem_mode_e'(mode);
          err_q  <= 1'b0;
          state  <= zero_area ? ST_FINISH : ST_FETCH;
        end
        ST_FETCH: begin
          num_neg_q <= a_w[DW];
          den_ext   <= b_w;
          den_mag_q <= magnitude(b_w);
          if (b_w == '0) begin
            den_zero_q <= 1'b1;
            res_q      <= '0;
            state      <= ST_STORE;
          end else begin
            den_zero_q <= 1'b0;
            state      <= ST_DIVIDE;
          end
        end
        ST_DIVIDE: if (div_fin) begin
          res_q <= narrow(floor_fix(div_rem, num_neg_q, den_ext), mode_q);
          state <= ST_STORE;
        end
        ST_STORE: begin
          if (den_zero_q) err_q <= 1'b1;
          state <= walk_last ? ST_FINISH : ST_FETCH;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (state != ST_IDLE);
  assign done          = (state == ST_FINISH);
  assign err_div0      = err_q;
  assign rd_addr       = walk_addr;
  assign wr_en         = (state == ST_STORE);
  assign wr_addr       = walk_addr;
  assign wr_data       = res_q;
  assign ev_zero_div   = wr_en && den_zero_q;
  assign ev_last_store = wr_en && walk_last;
  assign mode_bits     = mode_q;
  assign den_neg       = den_ext[DW];

endmodule

// File: rtl/tile_floor_rem_chk.sv
module tile_floor_rem_chk #(
  parameter int ROWS = 8,
  parameter int COLS = 8,
  parameter int DW   = 32,
  parameter int DIMW = 8,
  parameter int AW   = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [DIMW-1:0] valid_rows,
  input logic [DIMW-1:0] valid_cols,
  input logic            busy,
  input logic            done,
  input logic            err_div0,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic [1:0]      mode_bits,
  input logic            den_neg,
  input logic            ev_zero_div,
  input logic            ev_last_store
);

  localparam int HW = DW / 2;

  int rows_lim, cols_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_lim <= 0;
      cols_lim <= 0;
    end else if (start && !busy) begin
      rows_lim <= (int'(valid_rows) > ROWS) ? ROWS : int'(valid_rows);
      cols_lim <= (int'(valid_cols) > COLS) ? COLS : int'(valid_cols);
    end
  end

  // R1
  result_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_zero_div && mode_bits == 2'd0 && wr_data != '0) |-> (wr_data[DW-1] == den_neg));

  // R1
  result_sign16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ev_zero_div && mode_bits == 2'd2 && wr_data[HW-1:0] != '0) |-> (wr_data[HW-1] == den_neg));

  // R4
  write_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && (int'(wr_addr) / COLS) < rows_lim && (int'(wr_addr) % COLS) < cols_lim));

  // R5
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mode_bits[1]) |-> (wr_data[DW-1:HW] == '0));

  // R7
  zero_div_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_div |-> (wr_data == '0));

  // R7
  zero_div_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_zero_div |=> err_div0);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_div0 && !(start && !busy)) |=> err_div0);

  // R8
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last_store |=> done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

endmodule

bind tile_floor_rem tile_floor_rem_chk #(
  .ROWS(ROWS), .COLS(COLS), .DW(DW), .DIMW(DIMW), .AW(AW)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .valid_rows    (valid_rows),
  .valid_cols    (valid_cols),
  .busy          (busy),
  .done          (done),
  .err_div0      (err_div0),
  .wr_en         (wr_en),
  .wr_addr       (wr_addr),
  .wr_data       (wr_data),
  .mode_bits     (mode_bits),
  .den_neg       (den_neg),
  .ev_zero_div   (ev_zero_div),
  .ev_last_store (ev_last_store)
);

// File: tb/tile_floor_rem_test.sv
module tile_floor_rem_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 3;
  localparam int COLS = 4;
  localparam int DW   = 32;
  localparam int DIMW = 8;
  localparam int N    = ROWS * COLS;
  localparam int AW   = $clog2(N);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [DIMW-1:0] valid_rows = '0;
  logic [DIMW-1:0] valid_cols = '0;
  logic [1:0]      mode = '0;
  logic            busy, done, err_div0, wr_en;
  logic [AW-1:0]   rd_addr, wr_addr;
  logic [DW-1:0]   src0_data, src1_data, wr_data;

  logic [31:0] mem_a [N];
  logic [31:0] mem_b [N];
  logic [31:0] mem_d [N];

  int tests = 0;
  int fails = 0;
  int wr_count = 0;
  int ord_bad = 0;
  int base_cnt = 0;
  int cur_cols = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_floor_rem #(.ROWS(ROWS), .COLS(COLS), .DW(DW), .DIMW(DIMW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .valid_rows(valid_rows),
    .valid_cols(valid_cols), .mode(mode), .busy(busy), .done(done),
    .err_div0(err_div0), .rd_addr(rd_addr), .src0_data(src0_data),
    .src1_data(src1_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign src0_data = (int'(rd_addr) < N) ? mem_a[rd_addr] : '0;
  assign src1_data = (int'(rd_addr) < N) ? mem_b[rd_addr] : '0;

  // destination buffer and R3 order tracking
  always @(posedge clk) begin
    if (wr_en) begin
      int idx, want;
      idx  = wr_count - base_cnt;
      want = (idx / cur_cols) * COLS + (idx % cur_cols);
      if (int'(wr_addr) != want) ord_bad++;
      if (int'(wr_addr) < N) mem_d[wr_addr] = wr_data;
      wr_count++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic longint as_num(logic [31:0] v, int m);
    case (m)
      0: return longint'($signed(v));
      1: return longint'({32'h0, v});
      2: return longint'($signed(v[15:0]));
      default: return longint'({48'h0, v[15:0]});
    endcase
  endfunction

  function automatic logic [31:0] exp_rem(logic [31:0] a, logic [31:0] b, int m);
    longint x, y, q, r;
    x = as_num(a, m);
    y = as_num(b, m);
    if (y == 0) return 32'h0;
    q = x / y;
    if ((x % y) != 0 && ((x < 0) != (y < 0))) q = q - 1;
    r = x - y * q;
    return (m >= 2) ? {16'h0, r[15:0]} : r[31:0];
  endfunction

  function automatic logic [31:0] pick_a(int i);
    case (i % 16)
      0: return 32'd0;           1: return 32'd1;
      2: return 32'hFFFF_FFFF;   3: return 32'd7;
      4: return 32'hFFFF_FFF9;   5: return 32'd3;
      6: return 32'hFFFF_FFFD;   7: return 32'd100;
      8: return 32'hFFFF_FF9C;   9: return 32'h8000_0000;
      10: return 32'h7FFF_FFFF;  11: return 32'd13;
      12: return 32'hFFFF_8000;  13: return 32'h0000_7FFF;
      14: return 32'hFFFF_FFFE;  default: return 32'd65535;
    endcase
  endfunction

  function automatic logic [31:0] pick_b(int i);
    case (i % 16)
      0: return 32'd3;           1: return 32'hFFFF_FFFD;
      2: return 32'd1;           3: return 32'hFFFF_FFFF;
      4: return 32'd0;           5: return 32'd7;
      6: return 32'hFFFF_FFF9;   7: return 32'd2;
      8: return 32'hFFFF_FFFE;   9: return 32'h7FFF_FFFF;
      10: return 32'h8000_0000;  11: return 32'd5;
      12: return 32'hFFFF_FFFB;  13: return 32'd16;
      14: return 32'hFFFF_8001;  default: return 32'h0001_0001;
    endcase
  endfunction

  task automatic kick(input int m, input int nr, input int nc);
    int ec;
    ec = (nc > COLS) ? COLS : nc;
    cur_cols = (ec == 0) ? 1 : ec;
    base_cnt = wr_count;
    @(negedge clk);
    mode = 2'(m); valid_rows = DIMW'(nr); valid_cols = DIMW'(nc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    int cyc = 0;
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
    end
    ok = done;
  endtask

  task automatic run_case(input int m, input int nr, input int nc, input int k, input bit interfere);
    int er, ec, ord0;
    bit any_zero, ok;
    logic [31:0] e;
    er = (nr > ROWS) ? ROWS : nr;
    ec = (nc > COLS) ? COLS : nc;
    any_zero = 1'b0;
    for (int i = 0; i < N; i++) begin
      mem_a[i] = pick_a(i * 5 + k * 3) ^ ((m >= 2) ? 32'h5A5A_0000 : 32'h0);
      mem_b[i] = pick_b(i * 7 + k) ^ ((m >= 2) ? 32'hA5A5_0000 : 32'h0);
      mem_d[i] = 32'hC0DE_0000 | i;
      if ((i / COLS) < er && (i % COLS) < ec && as_num(mem_b[i], m) == 0) any_zero = 1'b1;
    end
    ord0 = ord_bad;
    kick(m, nr, nc);
    if (interfere && er * ec > 0) begin
      repeat (4) @(negedge clk);
      valid_rows = 8'd1; valid_cols = 8'd1; mode = 2'(m ^ 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_done(ok);
    check(ok, "R8 done seen", 32'(ok), 32'h1);
    if (!ok) return;
    @(negedge clk);
    check(!done, "R8 done single pulse", 32'(done), 32'h0);
    check(!busy, "R9 idle after run", 32'(busy), 32'h0);
    check(wr_count - base_cnt == er * ec, "R6 write count", 32'(wr_count - base_cnt), 32'(er * ec));
    check(ord_bad == ord0, "R3 row-major order", 32'(ord_bad - ord0), 32'h0);
    check(err_div0 == any_zero, "R7 zero divisor flag", 32'(err_div0), 32'(any_zero));
    for (int i = 0; i < N; i++) begin
      if ((i / COLS) < er && (i % COLS) < ec) begin
        e = exp_rem(mem_a[i], mem_b[i], m);
        check(mem_d[i] == e, (m >= 2) ? "R5 half-width remainder" : "R1 floored remainder", mem_d[i], e);
      end else begin
        check(mem_d[i] == (32'hC0DE_0000 | i), "R4 outside region untouched", mem_d[i], 32'hC0DE_0000 | i);
      end
    end
  endtask

  task automatic finish_up();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busy && !done && !err_div0 && !wr_en, "R10 reset outputs",
          {28'h0, busy, done, err_div0, wr_en}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 directed: -7 by 3 -> 2, 7 by -3 -> -2
    mem_a[0] = 32'hFFFF_FFF9; mem_b[0] = 32'd3;
    mem_a[1] = 32'd7;         mem_b[1] = 32'hFFFF_FFFD;
    for (int i = 2; i < N; i++) begin mem_a[i] = 0; mem_b[i] = 1; end
    for (int i = 0; i < N; i++) mem_d[i] = 32'h0;
    kick(0, 1, 2);
    wait_done(ok);
    @(negedge clk);
    check(mem_d[0] == 32'd2, "R2 sign fix to divisor", mem_d[0], 32'd2);
    check(mem_d[1] == 32'hFFFF_FFFE, "R2 sign fix to divisor", mem_d[1], 32'hFFFF_FFFE);

    // sweep modes x row counts x column counts (R1 R3 R4 R5 R6 R7 R8 R9)
    for (int m = 0; m < 4; m++)
      for (int nr = 0; nr <= ROWS + 1; nr++)
        for (int nc = 0; nc <= COLS + 1; nc++)
          run_case(m, nr, nc, m * 31 + nr * 7 + nc, ((nr + nc) % 2) == 1);

    finish_up();
  end

endmodule